// File: doc/BRIEF.md
# Region-Based Address Translator

This block sits on a memory-access master path and widens each 32-bit CPU address into a 48-bit system address. A table of sixteen programmable regions is searched in parallel for every request. Each region has a match base, a size given as a power of two, a 48-bit translated base and an enable. A region must be aligned to its own size, so a match is a masked compare of the upper address bits.

On a hit, the upper bits of the output come from the region's translated base and the bits below the region size come from the input address. When several enabled regions match, the lowest-numbered one wins. On a miss, the address is zero-extended to 48 bits and the hit flag stays low.

The table is loaded through a simple write port. Requests pass through on a valid/ready pair, either combinationally or through one register stage chosen by a parameter. The default is one register stage.

Top module: `addr_xlate`

## Requirements
- R1: After reset every region is disabled, so every accepted address leaves with `out_hit` low.
- R2: An enabled region of log2 size S matches an address when input bits 31..S equal the region base bits 31..S.
- R3: On a hit, `out_addr` bits 47..S are the translated base bits 47..S and bits S-1..0 are the input address bits S-1..0.
- R4: A region whose enable bit is clear never matches, whatever its base and size.
- R5: When more than one enabled region matches, the region with the lowest index is used.
- R6: On a miss, `out_addr` is the input address zero-extended to 48 bits, `out_hit` is 0 and `out_region` is 0.
- R7: Match-base bits below the region size have no effect on matching.
- R8: Translated-base bits below the region size have no effect on the output address.
- R9: A write with `cfg_we` high changes the table at that clock edge. `cfg_addr[5:2]` selects the region and `cfg_addr[1:0]` selects the field: 0 is the match base, 1 is translated bits 31..0, 2 is translated bits 47..32 (taken from data bits 15..0), and 3 is control (enable in bit 0, log2 size in bits 12..8). A request accepted at the same edge still uses the old table.
- R10: With the register stage, a request accepted at a clock edge appears on the output side after that edge. `in_ready` is high when the stage is empty or `out_ready` is high.
- R11: `out_region` gives the index of the winning region on a hit.
- R12: While `out_valid` is high and `out_ready` is low, the output valid, address, hit flag and region index hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 6 | Region index (bits 5..2) and field select (bits 1..0) |
| cfg_wdata | input | 32 | Table write data |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_addr | input | 32 | Untranslated address |
| out_valid | output | 1 | Translated request valid |
| out_ready | input | 1 | Downstream can take the translated request |
| out_addr | output | 48 | Translated address |
| out_hit | output | 1 | A region matched |
| out_region | output | 4 | Index of the winning region |

## Verification
A wrong table entry, enable bit or size field does not show until an address falls inside the affected window. It then shows as a wrong upper address, a wrong region index or a wrong hit flag on the very next output beat. A broken priority chain only shows when two enabled regions overlap, so the bench programs nested regions on purpose. A fault in the output stage shows within one cycle of a stall, as a changed or dropped beat. The reference model predicts every beat on every clock, so any such difference is reported in the cycle it first appears.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    FLD_MBASE = 2'd0,
    FLD_XLO   = 2'd1,
    FLD_XHI   = 2'd2,
    FLD_CTRL  = 2'd3
  } fld_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_SZ_LSB  = 8;
  localparam int CFG_DW       = 32;
endpackage

// File: rtl/xlat_region_file.sv
module xlat_region_file #(
  parameter int NREG = 16,
  parameter int IAW  = 32,
  parameter int OAW  = 48,
  parameter int LW   = $clog2(IAW),
  parameter int IDXW = $clog2(NREG)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDXW-1:0]               wr_idx,
  input  logic [1:0]                    wr_fld,
  input  logic [xlat_pkg::CFG_DW-1:0]   wr_data,
  output logic [IAW-1:0]                mbase_o [NREG],
  output logic [OAW-1:0]                xbase_o [NREG],
  output logic [NREG-1:0]               en_o,
  output logic [LW-1:0]                 size_o  [NREG]
);
  import xlat_pkg::*;
  localparam int XHW = OAW - 32;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic           sel;
    logic [IAW-1:0] mbase_d, mbase_q;
    logic [OAW-1:0] xbase_d, xbase_q;
    logic           en_d, en_q;
    logic [LW-1:0]  size_d, size_q;

    assign sel = wr_en && (wr_idx == IDXW'(r));

    always_comb begin
      mbase_d = mbase_q;
      xbase_d = xbase_q;
      en_d    = en_q;
      size_d  = size_q;
      if (sel) begin
        case (fld_e'(wr_fld))
          FLD_MBASE: mbase_d = wr_data[IAW-1:0];
          FLD_XLO:   xbase_d[31:0] = wr_data;
          FLD_XHI:   xbase_d[OAW-1:32] = wr_data[XHW-1:0];
          FLD_CTRL: begin
            en_d   = wr_data[CTRL_EN_BIT];
            size_d = wr_data[CTRL_SZ_LSB +: LW];
          end
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mbase_q <= '0;
        xbase_q <= '0;
        en_q    <= 1'b0;
        size_q  <= '0;
      end else if (sel) begin
        mbase_q <= mbase_d;
        xbase_q <= xbase_d;
        en_q    <= en_d;
        size_q  <= size_d;
      end
    end

    assign mbase_o[r] = mbase_q;
    assign xbase_o[r] = xbase_q;
    assign en_o[r]    = en_q;
    assign size_o[r]  = size_q;
  end
endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int NREG = 16,
  parameter int IAW  = 32,
  parameter int OAW  = 48,
  parameter int LW   = $clog2(IAW)
) (
  input  logic [IAW-1:0]  addr,
  input  logic [IAW-1:0]  mbase [NREG],
  input  logic [OAW-1:0]  xbase [NREG],
  input  logic [NREG-1:0] en,
  input  logic [LW-1:0]   size  [NREG],
  output logic [NREG-1:0] hit,
  output logic [OAW-1:0]  xaddr [NREG]
);
  for (genvar r = 0; r < NREG; r++) begin : g_cmp
    logic [IAW-1:0] low_mask;
    logic [IAW-1:0] diff;
    assign low_mask = ~({IAW{1'b1}} << size[r]);
    assign diff     = (addr ^ mbase[r]) & ~low_mask;
    assign hit[r]   = en[r] && (diff == '0);
    assign xaddr[r] = {xbase[r][OAW-1:IAW],
                       (xbase[r][IAW-1:0] & ~low_mask) | (addr & low_mask)};
  end
endmodule

// File: rtl/xlat_prio_select.sv
module xlat_prio_select #(
  parameter int NREG = 16,
  parameter int IAW  = 32,
  parameter int OAW  = 48,
  parameter int IDXW = $clog2(NREG)
) (
  input  logic [IAW-1:0]  addr,
  input  logic [NREG-1:0] hit,
  input  logic [OAW-1:0]  xaddr [NREG],
  output logic            any_hit,
  output logic [IDXW-1:0] win_idx,
  output logic [OAW-1:0]  res_addr
);
  always_comb begin
    win_idx = '0;
    for (int r = NREG - 1; r >= 0; r--) begin
      if (hit[r]) win_idx = IDXW'(r);
    end
  end

  assign any_hit  = |hit;
  assign res_addr = any_hit ? xaddr[win_idx] : {{(OAW-IAW){1'b0}}, addr};
endmodule

// File: rtl/xlat_out_stage.sv
module xlat_out_stage #(
  parameter int OAW  = 48,
  parameter int IDXW = 4,
  parameter bit PIPE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OAW-1:0]  in_addr,
  input  logic            in_hit,
  input  logic [IDXW-1:0] in_idx,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [OAW-1:0]  out_addr,
  output logic            out_hit,
  output logic [IDXW-1:0] out_idx
);
  if (PIPE) begin : g_reg
    logic            full_q, full_d;
    logic [OAW-1:0]  addr_q, addr_d;
    logic            hit_q, hit_d;
    logic [IDXW-1:0] idx_q, idx_d;
    logic            load;

    assign load     = !full_q || out_ready;
    assign in_ready = load;

    always_comb begin
      full_d = in_valid;
      addr_d = in_addr;
      hit_d  = in_hit;
      idx_d  = in_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_q <= 1'b0;
        addr_q <= '0;
        hit_q  <= 1'b0;
        idx_q  <= '0;
      end else if (load) begin
        full_q <= full_d;
        addr_q <= addr_d;
        hit_q  <= hit_d;
        idx_q  <= idx_d;
      end
    end

    assign out_valid = full_q;
    assign out_addr  = addr_q;
    assign out_hit   = hit_q;
    assign out_idx   = idx_q;
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
    assign in_ready   = out_ready;
    assign out_valid  = in_valid;
    assign out_addr   = in_addr;
    assign out_hit    = in_hit;
    assign out_idx    = in_idx;
  end
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate #(
  parameter int NREG = 16,
  parameter int IAW  = 32,
  parameter int OAW  = 48,
  parameter bit PIPE = 1'b1,
  localparam int IDXW = $clog2(NREG),
  localparam int LW   = $clog2(IAW),
  localparam int CAW  = IDXW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [CAW-1:0]  cfg_addr,
  input  logic [31:0]     cfg_wdata,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IAW-1:0]  in_addr,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [OAW-1:0]  out_addr,
  output logic            out_hit,
  output logic [IDXW-1:0] out_region
);
  logic [IAW-1:0]  mbase [NREG];
  logic [OAW-1:0]  xbase [NREG];
  logic [NREG-1:0] en;
  logic [LW-1:0]   size  [NREG];
  logic [NREG-1:0] hit;
  logic [OAW-1:0]  xaddr [NREG];
  logic            any_hit;
  logic [IDXW-1:0] win_idx;
  logic [OAW-1:0]  res_addr;

  xlat_region_file #(.NREG(NREG), .IAW(IAW), .OAW(OAW), .LW(LW), .IDXW(IDXW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_addr[CAW-1:2]),
    .wr_fld  (cfg_addr[1:0]),
    .wr_data (cfg_wdata),
    .mbase_o (mbase),
    .xbase_o (xbase),
    .en_o    (en),
    .size_o  (size)
  );

  xlat_match #(.NREG(NREG), .IAW(IAW), .OAW(OAW), .LW(LW)) u_match (
    .addr  (in_addr),
    .mbase (mbase),
    .xbase (xbase),
    .en    (en),
    .size  (size),
    .hit   (hit),
    .xaddr (xaddr)
  );

  xlat_prio_select #(.NREG(NREG), .IAW(IAW), .OAW(OAW), .IDXW(IDXW)) u_prio (
    .addr     (in_addr),
    .hit      (hit),
    .xaddr    (xaddr),
    .any_hit  (any_hit),
    .win_idx  (win_idx),
    .res_addr (res_addr)
  );

  xlat_out_stage #(.OAW(OAW), .IDXW(IDXW), .PIPE(PIPE)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_addr   (res_addr),
    .in_hit    (any_hit),
    .in_idx    (win_idx),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_hit   (out_hit),
    .out_idx   (out_region)
  );
endmodule

// File: rtl/xlat_checks.sv
module xlat_checks #(
  parameter int IAW  = 32,
  parameter int OAW  = 48,
  parameter int IDXW = 4,
  parameter bit PIPE = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [OAW-1:0]  out_addr,
  input logic            out_hit,
  input logic [IDXW-1:0] out_region
);
  p_miss_zext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_addr[OAW-1:IAW] == '0 && out_region == '0));

  if (PIPE) begin : g_pipe_chk
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
                                     && $stable(out_hit) && $stable(out_region)));

    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

    p_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !in_valid) |=> !out_valid);
  end else begin : g_comb_chk
    p_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> out_valid);

    p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_ready |-> in_ready);
  end
endmodule

bind addr_xlate xlat_checks #(.IAW(IAW), .OAW(OAW), .IDXW(IDXW), .PIPE(PIPE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_addr   (out_addr),
  .out_hit    (out_hit),
  .out_region (out_region)
);

// File: tb/tb_addr_xlate.sv
module tb_addr_xlate;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [5:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_addr;
  logic        out_valid;
  logic        out_ready;
  logic [47:0] out_addr;
  logic        out_hit;
  logic [3:0]  out_region;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  string cur_req = "R1";
  bit    cmp_on = 1'b0;

  addr_xlate dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_hit(out_hit), .out_region(out_region)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // reference model: table and one-entry output beat
  logic [31:0] m_base [16];
  logic [47:0] m_xb   [16];
  bit          m_en   [16];
  int          m_sz   [16];
  bit          m_v;
  logic [47:0] m_addr;
  bit          m_hit;
  int          m_reg;

  function automatic void ref_xlate(input logic [31:0] a, output logic [47:0] ra,
                                    output bit rh, output int rr);
    rh = 1'b0; rr = 0; ra = {16'h0, a};
    for (int r = 0; r < 16; r++) begin
      logic [31:0] lm;
      lm = 32'((64'd1 << m_sz[r]) - 64'd1);
      if (!rh && m_en[r] && ((a & ~lm) == (m_base[r] & ~lm))) begin
        rh = 1'b1; rr = r;
        ra = {m_xb[r][47:32], (m_xb[r][31:0] & ~lm) | (a & lm)};
      end
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_v <= 1'b0;
      for (int r = 0; r < 16; r++) begin
        m_en[r] <= 1'b0; m_sz[r] <= 0; m_base[r] <= '0; m_xb[r] <= '0;
      end
    end else begin
      if (!m_v || out_ready) begin
        logic [47:0] ta; bit th; int tr;
        ref_xlate(in_addr, ta, th, tr);
        m_v <= in_valid; m_addr <= ta; m_hit <= th; m_reg <= tr;
      end
      if (cfg_we) begin
        int r;
        r = int'(cfg_addr[5:2]);
        case (cfg_addr[1:0])
          2'd0: m_base[r] <= cfg_wdata;
          2'd1: m_xb[r][31:0] <= cfg_wdata;
          2'd2: m_xb[r][47:32] <= cfg_wdata[15:0];
          default: begin m_en[r] <= cfg_wdata[0]; m_sz[r] <= int'(cfg_wdata[12:8]); end
        endcase
      end
    end
  end

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check("in_ready", 64'(in_ready), 64'(!m_v || out_ready));
      check("out_valid", 64'(out_valid), 64'(m_v));
      if (m_v) begin
        check("out_addr", 64'(out_addr), 64'(m_addr));
        check("out_hit", 64'(out_hit), 64'(m_hit));
        check("out_region", 64'(out_region), 64'(m_reg));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #3;
  endtask

  task automatic cfg_wr(input int r, input int f, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = {4'(r), 2'(f)}; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic region(input int r, input logic [31:0] b, input logic [47:0] x,
                        input bit e, input int s);
    cfg_wr(r, 0, b);
    cfg_wr(r, 1, x[31:0]);
    cfg_wr(r, 2, {16'h0, x[47:32]});
    cfg_wr(r, 3, {19'h0, 5'(s), 7'h0, e});
  endtask

  task automatic send(input logic [31:0] a);
    in_valid = 1'b1; in_addr = a;
    tick();
    in_valid = 1'b0;
    tick();
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_addr = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    cmp_on = 1'b1;
    tick();

    // R1: reset state, all regions off
    cur_req = "R1";
    send(32'h4000_0000); send(32'hFFFF_FFFF); send(32'h0);

    // R2/R3/R11: single region
    cur_req = "R2";
    region(3, 32'h4000_0000, 48'hABCD_5000_0000, 1'b1, 28);
    send(32'h4123_4567); send(32'h3FFF_FFFF); send(32'h5000_0000);
    cur_req = "R3";
    send(32'h4FFF_FFFC);
    cur_req = "R11";
    send(32'h4000_0010);

    // R6: miss zero-extends
    cur_req = "R6";
    send(32'hC000_1234);

    // R5: nested regions, lower index wins
    cur_req = "R5";
    region(1, 32'h4000_0000, 48'h0077_0000_0000, 1'b1, 24);
    send(32'h40AB_CDEF); send(32'h4200_0000);

    // R4: disable region 1
    cur_req = "R4";
    cfg_wr(1, 3, {19'h0, 5'd24, 8'h00});
    send(32'h40AB_CDEF);

    // R7/R8: junk below size in both bases; size 0 and size 31 edges
    cur_req = "R7";
    region(5, 32'h8000_1FFF, 48'h1111_2222_3FFF, 1'b1, 12);
    send(32'h8000_1ABC); send(32'h8000_2ABC);
    cur_req = "R8";
    send(32'h8000_1001);
    region(0, 32'h0000_1234, 48'hFEDC_BA98_7654, 1'b1, 0);
    send(32'h0000_1234); send(32'h0000_1235);
    region(7, 32'hF000_0000, 48'h9_0000_0000, 1'b1, 31);
    send(32'hE000_0004);

    // R9: write in the same cycle as a request, then the next one
    cur_req = "R9";
    in_valid = 1'b1; in_addr = 32'h8000_1ABC;
    cfg_we = 1'b1; cfg_addr = {4'd5, 2'd3}; cfg_wdata = 32'h0;
    tick();
    cfg_we = 1'b0;
    tick();
    in_valid = 1'b0;
    tick();

    // R10/R12: random traffic with back-pressure and table churn
    cur_req = "R12";
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) begin
        int r;
        r = int'($urandom_range(0, 15));
        cur_req = "R9";
        region(r, $urandom, {16'($urandom), 32'($urandom)}, 1'($urandom),
               int'($urandom_range(0, 31)));
        cur_req = (i % 400 == 0) ? "R10" : "R12";
      end
      out_ready = 1'($urandom_range(0, 3) != 0);
      in_valid  = 1'($urandom);
      if ($urandom_range(0, 1) == 0) begin
        int r;
        r = int'($urandom_range(0, 15));
        in_addr = m_base[r] ^ 32'($urandom_range(0, 4095));
      end else begin
        in_addr = $urandom;
      end
      tick();
    end
    in_valid = 1'b0; out_ready = 1'b1;
    tick(); tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule